// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits on the read path of a flash array controller. While an internal program or erase runs, or while an erase is held in suspension, it replaces selected bits of the array read word with status bits. Software polls these bits to learn whether a write has finished. Outside those conditions the array word passes through unchanged. Command decoding, the write engine and the array itself are outside the block. It is told the busy state, the operation kind, the suspension state and region, the read address, and the polled bit of the word being programmed.

Three status positions are used:
- **Bit 7** is the polling bit. During a program it reads as the inverse of the programmed value. During an erase it reads 0.
- **Bit 6** is a toggle bit. It flips on each read of a busy array.
- **Bit 2** is a second toggle bit. It flips only during an erase or on a read of the suspended region.

Both toggle bits advance on read accesses, not on clock cycles. After a program or erase finishes, a settling window follows. During this window bit 7 already shows true data, while the other bits still carry the last status word.

Top module: `fsts_gen`

## Requirements
- R1: While busy with a program (`op_erase_i`=0), bit 7 of `rd_data_o` equals the inverse of `pgm_bit_i`. Once the settling window has ended, bit 7 shows array data.
- R2: While busy with an erase (`op_erase_i`=1), bit 7 reads 0. After completion and settling, the word equals the array word (all ones for an erased location).
- R3: While busy, bit 6 holds the toggle state. That state inverts once per read strobe, where a strobe is a rising edge of `rd_en_i` sampled on `clk`. Once the operation is over, bit 6 no longer alternates.
- R4: During a program, bit 2 carries array bit 2 and the second toggle state does not move. During an erase, bit 2 carries the second toggle state, which inverts once per read strobe.
- R5: While suspended and not busy, a read whose address matches `susp_addr_i` in the region bits returns bit 7=1, bit 6=1 and a bit 2 that inverts per read strobe. The region bits are the address bits at and above bit SECT_LSB (11) when `susp_blk_i`=0, and at and above bit BLK_LSB (15) when `susp_blk_i`=1.
- R6: While suspended and not busy, a read outside the suspended region returns the array word unchanged.
- R7: A program running during suspension gives an inverted bit 7 and a bit 6 that inverts per strobe. Bit 2 comes from the array. The second toggle state is left where it was.
- R8: A read strobe held high for several clock cycles advances each toggle state at most once.
- R9: When busy falls while not suspended, a window of SETTLE_CYC (default 8) cycles begins on the first clock edge that sees busy low. In this window bit 7 shows array bit 7, and every other bit shows the last word output while busy. After the window the array word is returned.
- R10: Reset clears both toggle states to 0, so the first strobe of a busy read shows bit 6 = 1. With nothing busy, suspended or settling, the output equals `array_data_i`.
- R11: While busy, all bits other than 7, 6 and 2 carry the array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal program or erase is running |
| op_erase_i | input | 1 | Running operation is an erase (1) or a program (0) |
| susp_i | input | 1 | An erase is suspended |
| susp_blk_i | input | 1 | Suspended region is a block (1) or a sector (0) |
| susp_addr_i | input | AW | Any address inside the suspended region |
| rd_addr_i | input | AW | Read address |
| pgm_bit_i | input | 1 | Bit 7 of the word being programmed |
| array_data_i | input | DW | Array read word |
| rd_en_i | input | 1 | Read enable; its rising edge is the read strobe |
| rd_data_o | output | DW | Read word with status bits inserted |

## Verification
A toggle state that fails to advance, or advances twice, shows up at the very next busy read. Two successive reads then return equal bit 6 (or bit 2 during an erase or a suspended-region read), so directed pairs of reads catch it. An erroneous region match appears on the first read of a neighbouring sector or block address, as 1s on bits 7 and 6 where array data belongs. A settling counter that is off by one is exposed by sampling the output on the last window cycle and on the cycle after it. A stale snapshot shows as a wrong bit 6 during the window.

// File: rtl/fsts_pkg.sv
package fsts_pkg;

   // Status bit positions; software polling routines decode these.
   localparam int POLL_BIT = 7;
   localparam int TGL_BIT  = 6;
   localparam int SUSP_BIT = 2;

   typedef enum logic [2:0] {
      RM_ARRAY  = 3'd0,
      RM_PROG   = 3'd1,
      RM_ERASE  = 3'd2,
      RM_HIT    = 3'd3,
      RM_SETTLE = 3'd4
   } rd_mode_e;

endpackage

// File: rtl/fsts_toggle.sv
module fsts_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en_i,
   input  logic adv_run_i,
   input  logic adv_sus_i,
   output logic tgl_run_o,
   output logic tgl_sus_o
);

   logic rd_q;
   logic strobe;

   // one strobe per read access, however long rd_en_i stays high
   assign strobe = rd_en_i & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         tgl_run_o <= 1'b0;
         tgl_sus_o <= 1'b0;
      end else begin
         rd_q <= rd_en_i;
         if (strobe && adv_run_i) tgl_run_o <= ~tgl_run_o;
         if (strobe && adv_sus_i) tgl_sus_o <= ~tgl_sus_o;
      end
   end

endmodule

// File: rtl/fsts_region.sv
module fsts_region #(
   parameter int AW       = 21,
   parameter int SECT_LSB = 11,
   parameter int BLK_LSB  = 15
) (
   input  logic [AW-1:0] rd_addr_i,
   input  logic [AW-1:0] susp_addr_i,
   input  logic          susp_blk_i,
   output logic          hit_o
);

   localparam logic [AW-1:0] ONE       = {{(AW-1){1'b0}}, 1'b1};
   localparam logic [AW-1:0] SECT_MASK = ~((ONE << SECT_LSB) - ONE);
   localparam logic [AW-1:0] BLK_MASK  = ~((ONE << BLK_LSB) - ONE);

   generate
      if (SECT_LSB >= BLK_LSB) begin : g_bad
         $error("fsts_region: sector must be smaller than block");
      end
      if (BLK_LSB >= AW) begin : g_bad_aw
         $error("fsts_region: block size exceeds address space");
      end
   endgenerate

   logic [AW-1:0] diff;
   logic [AW-1:0] mask;

   always_comb begin
      diff  = rd_addr_i ^ susp_addr_i;
      mask  = susp_blk_i ? BLK_MASK : SECT_MASK;
      hit_o = ((diff & mask) == '0);
   end

endmodule

// File: rtl/fsts_settle.sv
module fsts_settle #(
   parameter int DW         = 16,
   parameter int SETTLE_CYC = 8,
   parameter int POLL       = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          susp_i,
   input  logic [DW-1:0] cap_word_i,
   input  logic [DW-1:0] array_i,
   output logic          act_o,
   output logic [DW-1:0] word_o
);

   generate
      if (SETTLE_CYC == 0) begin : g_none
         assign act_o  = 1'b0;
         assign word_o = array_i;
      end else begin : g_win
         localparam int CW = $clog2(SETTLE_CYC + 1);
         localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

         logic          busy_q;
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt    <= '0;
            end else begin
               busy_q <= busy_i;
               if (busy_q && !busy_i && !susp_i) cnt <= LOAD;
               else if (cnt != '0)               cnt <= cnt - 1'b1;
            end
         end

         assign act_o = (cnt != '0);

         // per-bit snapshot of the last busy word; the polling bit is
         // never stored since it shows live data in the window
         for (genvar i = 0; i < DW; i++) begin : g_bit
            if (i == POLL) begin : g_live
               assign word_o[i] = array_i[i];
            end else begin : g_snap
               logic snap_q;
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n)      snap_q <= 1'b0;
                  else if (busy_i) snap_q <= cap_word_i[i];
               end
               assign word_o[i] = snap_q;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fsts_mux.sv
module fsts_mux
   import fsts_pkg::*;
#(
   parameter int DW = 16
) (
   input  rd_mode_e      mode_i,
   input  logic [DW-1:0] array_i,
   input  logic [DW-1:0] settle_i,
   input  logic          pgm_bit_i,
   input  logic          tgl_run_i,
   input  logic          tgl_sus_i,
   output logic [DW-1:0] word_o
);

   always_comb begin
      word_o = array_i;
      unique case (mode_i)
         RM_PROG: begin
            word_o[POLL_BIT] = ~pgm_bit_i;
            word_o[TGL_BIT]  = tgl_run_i;
         end
         RM_ERASE: begin
            word_o[POLL_BIT] = 1'b0;
            word_o[TGL_BIT]  = tgl_run_i;
            word_o[SUSP_BIT] = tgl_sus_i;
         end
         RM_HIT: begin
            word_o[POLL_BIT] = 1'b1;
            word_o[TGL_BIT]  = 1'b1;
            word_o[SUSP_BIT] = tgl_sus_i;
         end
         RM_SETTLE: word_o = settle_i;
         default:   word_o = array_i;
      endcase
   end

endmodule

// File: rtl/fsts_gen.sv
module fsts_gen
   import fsts_pkg::*;
#(
   parameter int AW         = 21,
   parameter int DW         = 16,
   parameter int SECT_LSB   = 11,
   parameter int BLK_LSB    = 15,
   parameter int SETTLE_CYC = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          op_erase_i,
   input  logic          susp_i,
   input  logic          susp_blk_i,
   input  logic [AW-1:0] susp_addr_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic          pgm_bit_i,
   input  logic [DW-1:0] array_data_i,
   input  logic          rd_en_i,
   output logic [DW-1:0] rd_data_o
);

   generate
      if (DW <= POLL_BIT) begin : g_bad_dw
         $error("fsts_gen: data width too small for status bits");
      end
      if (SETTLE_CYC < 0) begin : g_bad_settle
         $error("fsts_gen: negative settle window");
      end
   endgenerate

   logic          hit;
   logic          tgl_run;
   logic          tgl_sus;
   logic          adv_sus;
   logic          settle_act;
   logic [DW-1:0] settle_word;
   rd_mode_e      mode;

   fsts_region #(
      .AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
   ) u_region (
      .rd_addr_i  (rd_addr_i),
      .susp_addr_i(susp_addr_i),
      .susp_blk_i (susp_blk_i),
      .hit_o      (hit)
   );

   // bit 2 follows erase activity or reads of the suspended region
   assign adv_sus = busy_i ? op_erase_i : (susp_i & hit);

   fsts_toggle u_toggle (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en_i  (rd_en_i),
      .adv_run_i(busy_i),
      .adv_sus_i(adv_sus),
      .tgl_run_o(tgl_run),
      .tgl_sus_o(tgl_sus)
   );

   fsts_settle #(
      .DW(DW), .SETTLE_CYC(SETTLE_CYC), .POLL(POLL_BIT)
   ) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy_i),
      .susp_i    (susp_i),
      .cap_word_i(rd_data_o),
      .array_i   (array_data_i),
      .act_o     (settle_act),
      .word_o    (settle_word)
   );

   always_comb begin
      if (busy_i)          mode = op_erase_i ? RM_ERASE : RM_PROG;
      else if (susp_i)     mode = hit ? RM_HIT : RM_ARRAY;
      else if (settle_act) mode = RM_SETTLE;
      else                 mode = RM_ARRAY;
   end

   fsts_mux #(.DW(DW)) u_mux (
      .mode_i   (mode),
      .array_i  (array_data_i),
      .settle_i (settle_word),
      .pgm_bit_i(pgm_bit_i),
      .tgl_run_i(tgl_run),
      .tgl_sus_i(tgl_sus),
      .word_o   (rd_data_o)
   );

endmodule

// File: rtl/fsts_chk.sv
module fsts_chk #(
   parameter int AW       = 21,
   parameter int DW       = 16,
   parameter int SECT_LSB = 11,
   parameter int BLK_LSB  = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy_i,
   input logic          op_erase_i,
   input logic          susp_i,
   input logic          susp_blk_i,
   input logic [AW-1:0] susp_addr_i,
   input logic [AW-1:0] rd_addr_i,
   input logic          pgm_bit_i,
   input logic [DW-1:0] array_data_i,
   input logic          rd_en_i,
   input logic [DW-1:0] rd_data_o,
   input logic          tgl_run,
   input logic          tgl_sus,
   input logic          settle_act
);

   logic prev_rd;
   logic in_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_rd <= 1'b0;
      else        prev_rd <= rd_en_i;
   end

   always_comb begin
      if (susp_blk_i) in_reg = ((rd_addr_i >> BLK_LSB)  == (susp_addr_i >> BLK_LSB));
      else            in_reg = ((rd_addr_i >> SECT_LSB) == (susp_addr_i >> SECT_LSB));
   end

   a_r1_prog_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !op_erase_i) |-> (rd_data_o[7] == !pgm_bit_i));

   a_r2_erase_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && op_erase_i) |-> (rd_data_o[7] == 1'b0));

   a_r3_run_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && rd_en_i && !prev_rd) |=> (tgl_run != $past(tgl_run)));

   a_r4_prog_sus_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !op_erase_i) |=> $stable(tgl_sus));

   a_r5_susp_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && susp_i && in_reg) |-> (rd_data_o[7:6] == 2'b11));

   a_r6_susp_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && susp_i && !in_reg) |-> (rd_data_o == array_data_i));

   a_r8_one_per_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && prev_rd) |=> ($stable(tgl_run) && $stable(tgl_sus)));

   a_r9_settle_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (settle_act && !busy_i && !susp_i) |-> (rd_data_o[7] == array_data_i[7]));

   a_r10_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !susp_i && !settle_act) |-> (rd_data_o == array_data_i));

endmodule

bind fsts_gen fsts_chk #(
   .AW(AW), .DW(DW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_i      (busy_i),
   .op_erase_i  (op_erase_i),
   .susp_i      (susp_i),
   .susp_blk_i  (susp_blk_i),
   .susp_addr_i (susp_addr_i),
   .rd_addr_i   (rd_addr_i),
   .pgm_bit_i   (pgm_bit_i),
   .array_data_i(array_data_i),
   .rd_en_i     (rd_en_i),
   .rd_data_o   (rd_data_o),
   .tgl_run     (tgl_run),
   .tgl_sus     (tgl_sus),
   .settle_act  (settle_act)
);

// File: tb/test_fsts_gen.sv
module test_fsts_gen;

   localparam int AW     = 21;
   localparam int DW     = 16;
   localparam int SETTLE = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          busy, op_erase, susp, susp_blk, pgm_bit, rd_en;
   logic [AW-1:0] susp_addr, rd_addr;
   logic [DW-1:0] array_data, rd_data;

   int  n_chk  = 0;
   int  n_fail = 0;
   logic t6m = 1'b0;
   logic t2m = 1'b0;

   always #10 clk = ~clk;

   fsts_gen #(
      .AW(AW), .DW(DW), .SECT_LSB(11), .BLK_LSB(15), .SETTLE_CYC(SETTLE)
   ) i_fsts_gen (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op_erase),
      .susp_i(susp), .susp_blk_i(susp_blk), .susp_addr_i(susp_addr),
      .rd_addr_i(rd_addr), .pgm_bit_i(pgm_bit), .array_data_i(array_data),
      .rd_en_i(rd_en), .rd_data_o(rd_data)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] w);
      @(negedge clk);
      rd_addr = a;
      rd_en   = 1'b1;
      @(negedge clk);
      w     = rd_data;
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [DW-1:0] w;
      rst_n = 1'b0; busy = 0; op_erase = 0; susp = 0; susp_blk = 0; pgm_bit = 0;
      rd_en = 0; susp_addr = '0; rd_addr = '0; array_data = 16'hA5A5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle pass", rd_data, 16'hA5A5);
      array_data = 16'h3C3C;
      #1 w = rd_data;
      chk("R10 idle follows array", w, 16'h3C3C);
   endtask

   task automatic t_program;
      logic [DW-1:0] w, e;
      busy = 1; op_erase = 0; pgm_bit = 1'b0; array_data = 16'hFFFF;
      for (int k = 0; k < 3; k++) begin
         do_read(21'h000100, w);
         t6m = ~t6m;
         if (k == 0) chk("R10 first strobe bit6", {15'd0, w[6]}, 16'd1);
         e = 16'hFFFF; e[7] = 1'b1; e[6] = t6m;
         chk("R1 R3 R4 R11 program word", w, e);
      end
      // held read: one advance only
      @(negedge clk);
      rd_addr = 21'h000100; rd_en = 1'b1;
      t6m = ~t6m;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R8 held read bit6", {15'd0, rd_data[6]}, {15'd0, t6m});
      end
      rd_en = 1'b0;
      @(negedge clk);
      // completion and settling window
      busy = 0; array_data = 16'h1234;
      @(negedge clk);
      e = {8'hFF, 1'b0, t6m, 6'h3F};
      chk("R9 settle first cycle", rd_data, e);
      repeat (SETTLE - 1) @(negedge clk);
      chk("R9 settle last cycle", rd_data, e);
      @(negedge clk);
      chk("R9 settle over", rd_data, 16'h1234);
      do_read(21'h000100, w);
      chk("R1 R3 true data after", w, 16'h1234);
      do_read(21'h000100, w);
      chk("R3 no toggle after", w, 16'h1234);
   endtask

   task automatic t_erase;
      logic [DW-1:0] w, e;
      busy = 1; op_erase = 1; array_data = 16'h0F0F;
      for (int k = 0; k < 3; k++) begin
         do_read(21'h000040, w);
         t6m = ~t6m; t2m = ~t2m;
         e = 16'h0F0F; e[7] = 1'b0; e[6] = t6m; e[2] = t2m;
         chk("R2 R3 R4 erase word", w, e);
      end
      busy = 0; array_data = 16'hFFFF;
      repeat (SETTLE + 2) @(negedge clk);
      chk("R2 erased reads ones", rd_data, 16'hFFFF);
   endtask

   task automatic t_suspend;
      logic [DW-1:0] w, e;
      susp = 1; susp_blk = 0; susp_addr = 21'h012800; array_data = 16'h5555;
      for (int k = 0; k < 2; k++) begin
         do_read(21'h0128FF, w);
         t2m = ~t2m;
         e = 16'h5555; e[7] = 1'b1; e[6] = 1'b1; e[2] = t2m;
         chk("R5 sector hit", w, e);
      end
      do_read(21'h013000, w);
      chk("R6 other sector", w, 16'h5555);
      do_read(21'h017000, w);
      chk("R6 same block, sector mode", w, 16'h5555);
      susp_blk = 1;
      do_read(21'h017000, w);
      t2m = ~t2m;
      e = 16'h5555; e[7] = 1'b1; e[6] = 1'b1; e[2] = t2m;
      chk("R5 block hit", w, e);
      do_read(21'h018000, w);
      chk("R6 other block", w, 16'h5555);
      // program while suspended
      susp_blk = 0; busy = 1; op_erase = 0; pgm_bit = 1'b1; array_data = 16'hAAAA;
      for (int k = 0; k < 2; k++) begin
         do_read(21'h013000, w);
         t6m = ~t6m;
         e = 16'hAAAA; e[7] = 1'b0; e[6] = t6m;
         chk("R7 program in suspend", w, e);
      end
      busy = 0;
      @(negedge clk);
      chk("R7 no settle while suspended", rd_data, 16'hAAAA);
      do_read(21'h0128FF, w);
      t2m = ~t2m;
      e = 16'hAAAA; e[7] = 1'b1; e[6] = 1'b1; e[2] = t2m;
      chk("R7 second toggle kept", w, e);
      susp = 0;
      repeat (2) @(negedge clk);
      chk("R10 idle after resume", rd_data, 16'hAAAA);
   endtask

   initial begin
      t_reset;
      t_program;
      t_erase;
      t_suspend;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule